// File: doc/BRIEF.md
# Playback Coordination Sequencer

This block is the control hub of an audio playback pipeline built around a double-buffered sample store. It alternates ownership of the storage path between a host processor and the hardware playback loop. While the host owns it, the host may ask for a single block fetch at an address it supplies, or hand over to playback. While playback runs, every buffer swap reported by the audio buffer causes one storage read of the next block. Every fourth such read also launches a spectrum transform. Each completion of that transform produces one display refresh pulse.

All of the block's outputs are decoded from registered state. The storage start, transform start and display refresh outputs are single-cycle pulses. The block address is a register that is loaded by a host fetch and advanced by play requests and buffer swaps. The storage controller, transform engine, sample buffer and display sit outside the block and only exchange the handshake signals listed below.

Top module: `playback_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `stor_start`, `xform_start` and `disp_refresh` are 0 and `blk_addr` is 0.
- R2: After reset, host requests get no response until `stor_ready` has been seen high once. While waiting for it, a held `host_fetch` produces no `stor_start`.
- R3: When the host has control, a `host_fetch` request makes `blk_addr` equal to `host_addr` in the next cycle. In that same cycle, `stor_start` is high for exactly one cycle.
- R4: After a host fetch, `blk_addr` holds its value and host requests are ignored until `stor_ready` is high. Control then returns to the host.
- R5: When the host has control, a `host_play` request without `host_fetch` increments `blk_addr` by 1 in the next cycle, and playback begins one cycle later.
- R6: During playback, each one-cycle `swap_done` pulse produces exactly one `stor_start` pulse in the next cycle. In that cycle, `blk_addr` is one higher than before.
- R7: Counting buffer swaps from the start of playback, `xform_start` pulses together with the `stor_start` of swaps 4, 8, 12 and so on, and at no other time.
- R8: Each new start of playback restarts the swap count, so the first transform comes on the fourth swap after the restart, whatever count was left from earlier.
- R9: A low-to-high transition of `xform_done` during playback produces exactly one `disp_refresh` pulse, even if `xform_done` then stays high.
- R10: If a `xform_done` rise falls in the same cycle as a `swap_done` pulse, the swap is served first (its `stor_start` carries no refresh). The refresh is not lost: it follows as a single `disp_refresh` pulse within the next three cycles.
- R11: If `host_play` drops during playback, the block leaves playback. A later `swap_done` then causes no `stor_start`, and `blk_addr` does not change.
- R12: If `host_fetch` and `host_play` are both high while the host has control, the fetch takes priority and `blk_addr` takes `host_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stor_ready | input | 1 | Storage controller is idle and ready |
| host_fetch | input | 1 | Host requests a single block fetch |
| host_play | input | 1 | Host requests playback (level) |
| host_addr | input | ADDR_W | Block address supplied by the host for a fetch |
| swap_done | input | 1 | Audio buffer has switched halves (pulse) |
| xform_done | input | 1 | Spectrum transform finished (level) |
| stor_start | output | 1 | Pulse: storage controller reads block `blk_addr` |
| blk_addr | output | ADDR_W | Current storage block address |
| xform_start | output | 1 | Pulse: start the spectrum transform |
| disp_refresh | output | 1 | Pulse: display reloads the transform result |

## Verification
Two functions can compete for the same playback cycle: serving a buffer swap, and reacting to a transform completion. The bench raises `swap_done` and the rising edge of `xform_done` at the same clock edge. It checks that the first response cycle carries the storage read with the advanced address and no refresh. It then counts `disp_refresh` over the following cycles and expects exactly one pulse. A second scenario holds `xform_done` high for several cycles, to confirm that the edge, and not the level, is what produces the refresh.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;

    typedef enum logic [2:0] {
        PS_BOOT,
        PS_HOST,
        PS_FETCH,
        PS_FETCH_WAIT,
        PS_ARM,
        PS_PLAY,
        PS_SWAP,
        PS_REFRESH
    } pb_state_e;

endpackage

// File: rtl/pbseq_cadence.sv
module pbseq_cadence #(
    parameter int unsigned PERIOD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic fire
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign fire = step && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (step)
            cnt_d = fire ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R7: the count never passes the last position of the period
    p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R7: after a transform launch the count starts over
    p_wrap_after_fire_r7: assert property (@(posedge clk) disable iff (rst)
        fire |=> (cnt_q == '0));

    // R8: a playback restart leaves the count at zero
    p_clear_resets_r8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/pbseq_edge_pend.sv
module pbseq_edge_pend (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic consume,
    input  logic flush,
    output logic pending
);
    logic prev_d, prev_q;
    logic pend_d, pend_q;
    logic rise;

    assign rise    = level && !prev_q;
    assign pending = pend_q || rise;

    always_comb begin
        prev_d = level;
        if (flush)
            pend_d = 1'b0;
        else
            pend_d = (pend_q && !consume) || rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            pend_q <= pend_d;
        end
    end

    // R9: a rising edge is captured unless playback is being re-armed
    p_rise_captured_r9: assert property (@(posedge clk) disable iff (rst)
        (level && !prev_q && !flush) |=> pend_q);

    // R10: an unserved completion stays pending
    p_pend_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !consume && !flush) |=> pend_q);

endmodule

// File: rtl/playback_sequencer.sv
module playback_sequencer #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned XFORM_EVERY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stor_ready,
    input  logic              host_fetch,
    input  logic              host_play,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              swap_done,
    input  logic              xform_done,
    output logic              stor_start,
    output logic [ADDR_W-1:0] blk_addr,
    output logic              xform_start,
    output logic              disp_refresh
);
    import pbseq_pkg::*;

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef struct packed {
        pb_state_e         st;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t seq_d, seq_q;
    logic done_pending;
    logic cad_fire;

    pbseq_edge_pend u_done_edge (
        .clk     (clk),
        .rst     (rst),
        .level   (xform_done),
        .consume (seq_q.st == PS_REFRESH),
        .flush   (seq_q.st == PS_ARM),
        .pending (done_pending)
    );

    pbseq_cadence #(.PERIOD(XFORM_EVERY)) u_cadence (
        .clk   (clk),
        .rst   (rst),
        .clear (seq_q.st == PS_ARM),
        .step  (seq_q.st == PS_SWAP),
        .fire  (cad_fire)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            PS_BOOT: begin
                if (stor_ready) seq_d.st = PS_HOST;
            end
            PS_HOST: begin
                if (host_fetch) begin
                    seq_d.st   = PS_FETCH;
                    seq_d.addr = host_addr;
                end else if (host_play) begin
                    seq_d.st   = PS_ARM;
                    seq_d.addr = seq_q.addr + ADDR_ONE;
                end
            end
            PS_FETCH:      seq_d.st = PS_FETCH_WAIT;
            PS_FETCH_WAIT: begin
                if (stor_ready) seq_d.st = PS_HOST;
            end
            PS_ARM:        seq_d.st = PS_PLAY;
            PS_PLAY: begin
                if (!host_play) begin
                    seq_d.st = PS_BOOT;
                end else if (swap_done) begin
                    seq_d.st   = PS_SWAP;
                    seq_d.addr = seq_q.addr + ADDR_ONE;
                end else if (done_pending) begin
                    seq_d.st = PS_REFRESH;
                end
            end
            PS_SWAP:    seq_d.st = PS_PLAY;
            PS_REFRESH: seq_d.st = PS_PLAY;
            default:    seq_d.st = PS_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.st   <= PS_BOOT;
            seq_q.addr <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign stor_start   = (seq_q.st == PS_FETCH) || (seq_q.st == PS_SWAP);
    assign xform_start  = cad_fire;
    assign disp_refresh = (seq_q.st == PS_REFRESH);
    assign blk_addr     = seq_q.addr;

    // R3: storage start never lasts two cycles
    p_start_single_r3: assert property (@(posedge clk) disable iff (rst)
        stor_start |=> !stor_start);

    // R3: a host fetch loads the host address with the start pulse
    p_fetch_loads_r3: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == PS_HOST && host_fetch) |=>
            (stor_start && blk_addr == $past(host_addr)));

    // R4: address frozen while the fetch is outstanding
    p_wait_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == PS_FETCH_WAIT) |=> $stable(blk_addr));

    // R6: a swap during playback reads the next block
    p_swap_step_r6: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == PS_PLAY && host_play && swap_done) |=>
            (stor_start && blk_addr == ADDR_W'($past(blk_addr) + ADDR_ONE)));

    // R7: a transform launch always rides on a storage read
    p_xform_with_read_r7: assert property (@(posedge clk) disable iff (rst)
        xform_start |-> stor_start);

    // R9: refresh is a single-cycle pulse
    p_refresh_single_r9: assert property (@(posedge clk) disable iff (rst)
        disp_refresh |=> !disp_refresh);

    // R11: dropping play silences every pulse in the next cycle
    p_drop_play_r11: assert property (@(posedge clk) disable iff (rst)
        (seq_q.st == PS_PLAY && !host_play) |=>
            (!stor_start && !xform_start && !disp_refresh));

endmodule

// File: tb/playback_sequencer_tb_top.sv
`timescale 1ns/1ps
module playback_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        stor_ready, host_fetch, host_play, swap_done, xform_done;
    logic [31:0] host_addr;
    logic        stor_start, xform_start, disp_refresh;
    logic [31:0] blk_addr;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    logic [31:0] exp_addr;

    always #2.5 clk = ~clk;

    playback_sequencer dut_i (
        .clk          (clk),
        .rst          (rst),
        .stor_ready   (stor_ready),
        .host_fetch   (host_fetch),
        .host_play    (host_play),
        .host_addr    (host_addr),
        .swap_done    (swap_done),
        .xform_done   (xform_done),
        .stor_start   (stor_start),
        .blk_addr     (blk_addr),
        .xform_start  (xform_start),
        .disp_refresh (disp_refresh)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        stor_ready = 0; host_fetch = 0; host_play = 0;
        swap_done = 0; xform_done = 0; host_addr = '0;
        repeat (3) @(negedge clk);
        chk("R1", "start in reset", stor_start, 0);
        chk("R1", "addr in reset", blk_addr, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "pulses after reset", {xform_start, disp_refresh, stor_start}, 0);
        chk("R1", "addr after reset", blk_addr, 0);
    endtask

    task automatic t_boot_gate();
        int n = 0;
        host_fetch = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            n += int'(stor_start);
        end
        chk("R2", "fetch before ready", n, 0);
        host_fetch = 1'b0;
        stor_ready = 1'b1;
        @(negedge clk);
        stor_ready = 1'b0;
        @(negedge clk);
        chk("R2", "no start on handoff", stor_start, 0);
    endtask

    task automatic t_fetch_then_play();
        host_addr  = 32'h1000_0040;
        host_fetch = 1'b1;
        host_play  = 1'b1;
        @(negedge clk);
        chk("R3", "fetch start pulse", stor_start, 1);
        chk("R12", "fetch wins over play", blk_addr, 32'h1000_0040);
        host_fetch = 1'b0;
        @(negedge clk);
        chk("R3", "start is one cycle", stor_start, 0);
        repeat (3) @(negedge clk);
        chk("R4", "addr held while waiting", blk_addr, 32'h1000_0040);
        chk("R4", "no start while waiting", stor_start, 0);
        stor_ready = 1'b1;
        @(negedge clk);
        stor_ready = 1'b0;
        chk("R4", "addr on return to host", blk_addr, 32'h1000_0040);
        @(negedge clk);
        chk("R5", "play increments addr", blk_addr, 32'h1000_0041);
        chk("R5", "no start on play", stor_start, 0);
        exp_addr = 32'h1000_0041;
        @(negedge clk);
    endtask

    task automatic do_swap(input logic xexp, input string req);
        swap_done = 1'b1;
        @(negedge clk);
        swap_done = 1'b0;
        exp_addr  = exp_addr + 1;
        chk("R6", "swap read pulse", stor_start, 1);
        chk("R6", "swap addr step", blk_addr, exp_addr);
        chk(req, "transform launch", xform_start, xexp);
        @(negedge clk);
        chk("R6", "read pulse ends", {stor_start, xform_start}, 0);
    endtask

    task automatic t_cadence();
        for (int i = 0; i < 8; i++) do_swap((i % 4) == 3, "R7");
    endtask

    task automatic t_restart();
        do_swap(1'b0, "R7");
        do_swap(1'b0, "R7");
        host_play = 1'b0;
        @(negedge clk);
        swap_done = 1'b1;
        @(negedge clk);
        swap_done = 1'b0;
        chk("R11", "no read after play drop", stor_start, 0);
        @(negedge clk);
        chk("R11", "addr unchanged after drop", blk_addr, exp_addr);
        stor_ready = 1'b1;
        @(negedge clk);
        stor_ready = 1'b0;
        host_play  = 1'b1;
        @(negedge clk);
        exp_addr = exp_addr + 1;
        chk("R5", "replay increments addr", blk_addr, exp_addr);
        @(negedge clk);
        for (int i = 0; i < 4; i++) do_swap(i == 3, "R8");
    endtask

    task automatic t_refresh();
        int nr = 0;
        int ns = 0;
        xform_done = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            nr += int'(disp_refresh);
            ns += int'(stor_start);
        end
        chk("R9", "one refresh per rise", nr, 1);
        chk("R9", "no read from refresh", ns, 0);
        xform_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_collide();
        int nr = 0;
        swap_done  = 1'b1;
        xform_done = 1'b1;
        @(negedge clk);
        swap_done = 1'b0;
        exp_addr  = exp_addr + 1;
        chk("R10", "swap served first", stor_start, 1);
        chk("R10", "no refresh with swap", disp_refresh, 0);
        chk("R10", "addr on collision", blk_addr, exp_addr);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            nr += int'(disp_refresh);
        end
        chk("R10", "refresh not lost", nr, 1);
        xform_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_boot_gate();
        t_fetch_then_play();
        t_cadence();
        t_restart();
        t_refresh();
        t_collide();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule